// File: doc/BRIEF.md
# Sector Data Checksum Checker

This block verifies the integrity of one decoded sector data field. It takes a stream of 260 bytes, one per cycle in which `byte_vld` is high. The first 256 bytes are the payload and the last 4 are check bytes. The first three payload bytes seed three 8-bit state registers. Each of the remaining 253 payload bytes then advances the state by one shift-and-xor step.

When the stream ends, the three state registers are compared with the first three check bytes. The last check byte must equal a fixed marker value. The checker is not a polynomial CRC. It is a byte-serial mixing function that is invertible for each step.

A `start` pulse arms the block for a new sector. After the final byte, a one-cycle `done` pulse is raised, together with a `pass` or `fail` verdict that stays valid until the next `start`.

Top module: `sector_sum_check`

## Requirements
- R1: After reset, `done`, `pass` and `fail` are low and the block expects payload byte 0. A `start` clears `pass` and `fail` in the following cycle and sets the expected byte back to byte 0.
- R2: Accepted bytes 0, 1 and 2 are loaded into state registers A, B and C, in that order.
- R3: For each of bytes 3 to 255, the new A is the old B, with bit 0 inverted when bit 7 of the old A is 1.
- R4: For each of bytes 3 to 255, the new B is the old A shifted left by one bit (8-bit result, bit 0 zero), xor the old C.
- R5: For each of bytes 3 to 255, the new C is the old A xor the incoming byte. Exactly 253 such updates are made, and a change to any single payload byte gives a fail.
- R6: Byte 256 is compared with A, byte 257 with B, and byte 258 with C. Any mismatch gives a fail.
- R7: Byte 259 must equal 0x58, or the result is a fail.
- R8: `done` is high for exactly one cycle, the cycle after byte 259 is accepted. In that same cycle exactly one of `pass` and `fail` is high.
- R9: `pass` and `fail` keep their value until the next `start`.
- R10: Bytes offered after byte 259 and before the next `start` are ignored. They raise no `done` and do not change the verdict.
- R11: When `start` and `byte_vld` are high in the same cycle, that byte is taken as byte 0 of the new sector.
- R12: Cycles with `byte_vld` low leave the byte position and the state unchanged, so gaps in the stream do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arms the block for a new sector |
| byte_vld | input | 1 | `byte_in` holds a stream byte |
| byte_in | input | 8 | Decoded sector byte |
| done | output | 1 | One-cycle pulse after the final byte |
| pass | output | 1 | Checksum and marker matched |
| fail | output | 1 | Checksum or marker did not match |

## Verification
Two of the block's functions can fall in the same cycle: restarting the sequence on `start` and accepting a byte. The bench provokes this in two places. In one, it abandons a partly sent sector by raising `start` together with the first byte of a new sector. In the other, it restarts right after a finished sector. Each case is judged by whether the new sector, built by the bench model, gets the correct verdict. A second pairing is tested by offering extra bytes after the final byte, which must leave `done` low and the verdict unchanged.

// File: rtl/sector_sum_check.sv
module sector_sum_check #(
  parameter int          DATA_BYTES = 256,
  parameter logic [7:0]  MARKER     = 8'h58
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       done,
  output logic       pass,
  output logic       fail
);
  localparam int CHECKS = 4;
  localparam int TOTAL  = DATA_BYTES + CHECKS;
  localparam int CW     = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    ra, rb, rc;
  logic          bad, done_q, pass_q, fail_q;

  wire [CW-1:0] idx     = start ? '0 : cnt;
  wire          full    = (cnt == CW'(TOTAL));
  wire          take    = byte_vld && (start || !full);
  wire          is_chk  = (idx >= CW'(DATA_BYTES));
  wire          is_last = (idx == CW'(TOTAL - 1));
  wire [7:0]    want    = (idx == CW'(DATA_BYTES))     ? ra :
                          (idx == CW'(DATA_BYTES + 1)) ? rb :
                          (idx == CW'(DATA_BYTES + 2)) ? rc : MARKER;
  wire          miss    = take && is_chk && (byte_in != want);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      ra     <= '0;
      rb     <= '0;
      rc     <= '0;
      bad    <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        cnt    <= '0;
        bad    <= 1'b0;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (take) begin
        cnt <= idx + CW'(1);
        if (idx == CW'(0))      ra <= byte_in;
        else if (idx == CW'(1)) rb <= byte_in;
        else if (idx == CW'(2)) rc <= byte_in;
        else if (!is_chk) begin
          ra <= rb ^ {7'b0, ra[7]};
          rb <= {ra[6:0], 1'b0} ^ rc;
          rc <= ra ^ byte_in;
        end
        if (miss) bad <= 1'b1;
        if (is_last) begin
          done_q <= 1'b1;
          pass_q <= !(bad || miss);
          fail_q <= bad || miss;
        end
      end
    end
  end

  assign done = done_q;
  assign pass = pass_q;
  assign fail = fail_q;

  // R8: done lasts one cycle and carries exactly one verdict
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass ^ fail));
  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n) !(pass && fail));
  // R1: start clears the verdict
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n) start |=> (!pass && !fail && !done));
  // R9: verdict holds until start
  a_r9_pass_hold: assert property (@(posedge clk) disable iff (!rst_n) (pass && !start) |=> pass);
  a_r9_fail_hold: assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail);
  // R10: after the final byte the position stays put until start
  a_r10_parked: assert property (@(posedge clk) disable iff (!rst_n) (full && !start) |=> $stable(cnt) && !done);
  // R12: idle cycles do not move state
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n) (!byte_vld && !start) |=> ($stable(cnt) && $stable(ra) && $stable(rb) && $stable(rc)));
endmodule

// File: tb/sector_sum_check_tb.sv
`timescale 1ns/1ps
module sector_sum_check_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic done, pass, fail;
  int n_run = 0, n_fail = 0;
  logic [7:0] sbuf [260];

  always #4 clk = ~clk;

  sector_sum_check u_dut (.clk, .rst_n, .start, .byte_vld, .byte_in, .done, .pass, .fail);

  // {pattern[7:0], kind[2:0], gaps, expect_pass}
  // kind: 0 clean, 1 bad A byte, 2 bad B byte, 3 bad C byte, 4 bad marker, 5 payload flip, 6 seed flip
  localparam logic [12:0] VEC [10] = '{
    {8'h13, 3'd0, 1'b0, 1'b1}, {8'hA7, 3'd0, 1'b1, 1'b1}, {8'h00, 3'd0, 1'b0, 1'b1},
    {8'hFF, 3'd0, 1'b0, 1'b1}, {8'h5C, 3'd1, 1'b0, 1'b0}, {8'h39, 3'd2, 1'b1, 1'b0},
    {8'hC2, 3'd3, 1'b0, 1'b0}, {8'h81, 3'd4, 1'b0, 1'b0}, {8'h6E, 3'd5, 1'b0, 1'b0},
    {8'hD4, 3'd6, 1'b0, 1'b0}
  };

  task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] pat, input int kind);
    logic [7:0] a, b, c, na, nb;
    for (int i = 0; i < 256; i++) sbuf[i] = 8'((i * 37 + pat) ^ (i >> 3) ^ (pat << 1));
    a = sbuf[0]; b = sbuf[1]; c = sbuf[2];
    for (int i = 3; i < 256; i++) begin
      na = b ^ {7'b0, a[7]};
      nb = {a[6:0], 1'b0} ^ c;
      c  = a ^ sbuf[i];
      a  = na; b = nb;
    end
    sbuf[256] = a; sbuf[257] = b; sbuf[258] = c; sbuf[259] = 8'h58;
    case (kind)
      1: sbuf[256] ^= 8'h01;
      2: sbuf[257] ^= 8'h80;
      3: sbuf[258] ^= 8'h10;
      4: sbuf[259] = 8'h59;
      5: sbuf[100] ^= 8'h04;
      6: sbuf[1]   ^= 8'h20;
      default: ;
    endcase
  endtask

  task automatic send(input logic gaps, input logic with_start);
    for (int i = 0; i < 260; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk); byte_vld = 1'b0; byte_in = 8'hE1; start = 1'b0;
      end
      @(negedge clk);
      byte_vld = 1'b1; byte_in = sbuf[i]; start = with_start && (i == 0);
    end
    @(negedge clk); byte_vld = 1'b0; start = 1'b0;
  endtask

  task automatic judge(input logic exp, input string req);
    check(done == 1'b1, "R8", "done after byte 259", done, 1);
    check(pass == exp, req, "pass", pass, exp);
    check(fail == !exp, req, "fail", fail, !exp);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
    check(pass == exp, "R9", "pass held", pass, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !pass && !fail, "R1", "reset outputs", {done, pass, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !pass && !fail, "R1", "after reset", {done, pass, fail}, 0);

    // Table walk; clean vectors exercise R2 R3 R4 R5 R12
    for (int v = 0; v < 10; v++) begin
      logic [12:0] e;
      e = VEC[v];
      build(e[12:5], int'(e[4:2]));
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(!pass && !fail, "R1", "start clears", {pass, fail}, 0);
      send(e[1], 1'b0);
      case (e[4:2])
        3'd0: judge(e[0], "R2 R3 R4 R5 R12");
        3'd1, 3'd2, 3'd3: judge(e[0], "R6");
        3'd4: judge(e[0], "R7");
        default: judge(e[0], "R5 R2");
      endcase
    end

    // R10: extra bytes after the end are ignored
    build(8'h42, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    send(1'b0, 1'b0);
    judge(1'b1, "R10 base");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = 8'(i * 29 + 3);
    end
    @(negedge clk); byte_vld = 1'b0;
    @(negedge clk);
    check(!done && pass && !fail, "R10", "extra bytes ignored", {done, pass, fail}, 3'b010);

    // R11: abandon a partial sector; start shares the cycle with the new byte 0
    build(8'h77, 0);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = 8'(i ^ 8'h5A);
    end
    send(1'b0, 1'b1);
    judge(1'b1, "R11 mid-stream");

    // R11 with a failing sector directly after a finished one
    build(8'h1B, 3);
    send(1'b1, 1'b1);
    judge(1'b0, "R11 back-to-back");

    // R1: a lone start clears a fail verdict
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!pass && !fail && !done, "R1", "start clears fail", {done, pass, fail}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule